// File: doc/BRIEF.md
# Line Transfer Pulse Sequencer

This block drives the transfer strobes that, at the start of every line, move the charge collected in a linear image sensor's photodiodes into its readout shift register. A single line-start strobe launches a fixed-shape sequence:

- a guard interval;
- the first transfer pulse;
- a second guard interval;
- in dual mode only, the second transfer pulse and a closing guard interval.

While the sequence runs, a busy flag tells the pixel clock generator to hold off.

All phase lengths are counted in pixel-rate clock enables, not in system clocks. The three lengths come from three width inputs: first pulse, second pulse and guard.

The configuration is sampled when a line is accepted, so a line already in progress keeps its shape. The exception is output polarity, which is a static board-level setting and applies at once. Each pulse can also be disabled. A disabled pulse stays at its inactive level but keeps its time slot, so the line length does not depend on which pulses are enabled.

There is no data stream at this block's edges, so every pin is a plain level or strobe without a handshake.

Top module: `xfer_pulse_seq`

## Requirements
- R1: After reset `busy` is 0, and each pulse output sits at its inactive level, which equals its invert input (0 when not inverted, 1 when inverted).
- R2: A `line_start` that is high at a rising clock edge while idle starts a sequence, and `busy` is 1 from that edge on. That edge counts no pixel enable.
- R3: Once started, the phases run in a fixed order, and each phase lasts a set number of edges at which `pix_en` is high. The order is guard (`cfg_wg`), pulse 1 (`cfg_w1`), guard (`cfg_wg`), then in dual mode pulse 2 (`cfg_w2`) and guard (`cfg_wg`). `busy` falls at the edge that completes the last phase.
- R4: A width value of 0 behaves exactly like a width of 1.
- R5: With `cfg_dual`=0, the sequence ends after the second guard, and `tr2` never leaves its inactive level.
- R6: A pulse output is the XOR of its invert input and its active state: an active pulse drives 1 when the invert input is 0 and 0 when it is 1. The invert inputs act immediately and are not sampled at line start.
- R7: A pulse whose disable input was 1 at line start stays at its inactive level for the whole line, yet its slot still lasts its programmed width. The `busy` duration is therefore unchanged.
- R8: A `line_start` that arrives while `busy` is 1 is ignored: the running sequence neither restarts nor changes length.
- R9: At edges where `pix_en` is 0, no phase advances and no width count progresses.
- R10: Widths, mode and disable bits are captured at the accepting edge. Changing them during a line does not alter that line.
- R11: The two pulses are never active together, and a pulse is active only while `busy` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_start | input | 1 | Line-start strobe, sampled at rising edges |
| pix_en | input | 1 | Pixel-rate clock enable; phases count its high edges |
| cfg_dual | input | 1 | 1: two pulses per line, 0: first pulse only |
| cfg_w1 | input | W | First pulse width in pixel enables (0 means 1) |
| cfg_w2 | input | W | Second pulse width in pixel enables (0 means 1) |
| cfg_wg | input | W | Guard interval width in pixel enables (0 means 1) |
| cfg_inv1 | input | 1 | Invert output polarity of the first pulse |
| cfg_inv2 | input | 1 | Invert output polarity of the second pulse |
| cfg_dis1 | input | 1 | Suppress the first pulse (its slot is kept) |
| cfg_dis2 | input | 1 | Suppress the second pulse (its slot is kept) |
| tr1 | output | 1 | First transfer pulse |
| tr2 | output | 1 | Second transfer pulse |
| busy | output | 1 | Sequence in progress; pixel clocking must hold off |

## Verification
On every cycle, the assertions check the following:
- the sequencer only steps to the next phase in order;
- it never moves while `pix_en` is low;
- a strobe cannot restart a busy line;
- single mode never reaches the second pulse;
- the captured configuration stays frozen mid-line;
- the two pulses never overlap, and neither is active outside `busy`.

Only the bench scenarios can show the rest:
- the exact length of each phase;
- the zero-width substitution;
- the kept slot of a disabled pulse;
- the live effect of polarity.

For these, a reference model is compared against all three outputs at every cycle, and whole-line durations are checked against sums computed from the requested widths.

// File: rtl/xpg_pkg.sv
package xpg_pkg;
  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_GUARD0 = 3'd1,
    PH_PULSE1 = 3'd2,
    PH_GUARD1 = 3'd3,
    PH_PULSE2 = 3'd4,
    PH_GUARD2 = 3'd5
  } phase_t;

  localparam int NUM_PULSES = 2;
  localparam int NUM_WIDTHS = 3;  // pulse1, pulse2, guard
endpackage

// File: rtl/xpg_cfg_snap.sv
module xpg_cfg_snap #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         dual_i,
  input  logic [1:0]   dis_i,
  input  logic [W-1:0] w1_i,
  input  logic [W-1:0] w2_i,
  input  logic [W-1:0] wg_i,
  output logic         dual_o,
  output logic [1:0]   dis_o,
  output logic [W-1:0] w1_o,
  output logic [W-1:0] w2_o,
  output logic [W-1:0] wg_o
);
  import xpg_pkg::*;

  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] w_in  [NUM_WIDTHS];
  logic [W-1:0] w_reg [NUM_WIDTHS];

  assign w_in[0] = w1_i;
  assign w_in[1] = w2_i;
  assign w_in[2] = wg_i;

  // Zero is replaced by one on capture, so downstream never sees a zero limit.
  for (genvar k = 0; k < NUM_WIDTHS; k++) begin : g_width
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    w_reg[k] <= ONE;
      else if (load) w_reg[k] <= (w_in[k] == '0) ? ONE : w_in[k];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dual_o <= 1'b0;
      dis_o  <= 2'b00;
    end else if (load) begin
      dual_o <= dual_i;
      dis_o  <= dis_i;
    end
  end

  assign w1_o = w_reg[0];
  assign w2_o = w_reg[1];
  assign wg_o = w_reg[2];

  p_snap_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(w1_o) && $stable(w2_o) && $stable(wg_o) &&
               $stable(dual_o) && $stable(dis_o)));
endmodule

// File: rtl/xpg_width_cnt.sv
module xpg_width_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         pix_en,
  input  logic [W-1:0] limit,
  output logic         done
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] cnt;

  assign done = pix_en && (cnt == limit - ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (clear)  cnt <= '0;
    else if (pix_en) cnt <= cnt + ONE;
  end

  p_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !pix_en) |=> $stable(cnt));

  p_limit_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    limit != '0);
endmodule

// File: rtl/xpg_phase_seq.sv
module xpg_phase_seq
  import xpg_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   line_start,
  input  logic   dual,
  input  logic   done,
  output phase_t phase,
  output logic   load,
  output logic   clear
);
  phase_t phase_nxt;

  assign load  = (phase == PH_IDLE) && line_start;
  assign clear = load || done;

  always_comb begin
    phase_nxt = phase;
    unique case (phase)
      PH_IDLE:   if (load) phase_nxt = PH_GUARD0;
      PH_GUARD0: if (done) phase_nxt = PH_PULSE1;
      PH_PULSE1: if (done) phase_nxt = PH_GUARD1;
      PH_GUARD1: if (done) phase_nxt = dual ? PH_PULSE2 : PH_IDLE;
      PH_PULSE2: if (done) phase_nxt = PH_GUARD2;
      PH_GUARD2: if (done) phase_nxt = PH_IDLE;
      default:             phase_nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= PH_IDLE;
    else        phase <= phase_nxt;
  end

  p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE && line_start) |=> phase == PH_GUARD0);

  p_no_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_IDLE && phase != PH_GUARD0 && line_start) |=> phase != PH_GUARD0);

  p_hold_phase_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_IDLE && !done) |=> $stable(phase));

  p_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_PULSE1) |=> (phase == PH_PULSE1 || phase == PH_GUARD1));

  p_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_GUARD1 && !dual) |=> (phase == PH_GUARD1 || phase == PH_IDLE));
endmodule

// File: rtl/xpg_pulse_drv.sv
module xpg_pulse_drv (
  input  logic in_slot,
  input  logic suppress,
  input  logic invert,
  output logic asserted,
  output logic pin
);
  assign asserted = in_slot && !suppress;
  assign pin      = invert ^ asserted;
endmodule

// File: rtl/xfer_pulse_seq.sv
module xfer_pulse_seq #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         line_start,
  input  logic         pix_en,
  input  logic         cfg_dual,
  input  logic [W-1:0] cfg_w1,
  input  logic [W-1:0] cfg_w2,
  input  logic [W-1:0] cfg_wg,
  input  logic         cfg_inv1,
  input  logic         cfg_inv2,
  input  logic         cfg_dis1,
  input  logic         cfg_dis2,
  output logic         tr1,
  output logic         tr2,
  output logic         busy
);
  import xpg_pkg::*;

  phase_t       phase;
  logic         load, clear, done;
  logic         dual_s;
  logic [1:0]   dis_s;
  logic [W-1:0] w1_s, w2_s, wg_s;
  logic [W-1:0] limit;
  logic [NUM_PULSES-1:0] inv_v, act_v, pin_v;

  xpg_cfg_snap #(.W(W)) u_snap (
    .clk(clk), .rst_n(rst_n), .load(load),
    .dual_i(cfg_dual), .dis_i({cfg_dis2, cfg_dis1}),
    .w1_i(cfg_w1), .w2_i(cfg_w2), .wg_i(cfg_wg),
    .dual_o(dual_s), .dis_o(dis_s),
    .w1_o(w1_s), .w2_o(w2_s), .wg_o(wg_s)
  );

  xpg_phase_seq u_seq (
    .clk(clk), .rst_n(rst_n), .line_start(line_start),
    .dual(dual_s), .done(done),
    .phase(phase), .load(load), .clear(clear)
  );

  always_comb begin
    unique case (phase)
      PH_PULSE1: limit = w1_s;
      PH_PULSE2: limit = w2_s;
      default:   limit = wg_s;
    endcase
  end

  xpg_width_cnt #(.W(W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clear(clear), .pix_en(pix_en),
    .limit(limit), .done(done)
  );

  assign inv_v = {cfg_inv2, cfg_inv1};

  for (genvar i = 0; i < NUM_PULSES; i++) begin : g_pulse
    localparam phase_t SLOT = (i == 0) ? PH_PULSE1 : PH_PULSE2;
    xpg_pulse_drv u_drv (
      .in_slot(phase == SLOT), .suppress(dis_s[i]), .invert(inv_v[i]),
      .asserted(act_v[i]), .pin(pin_v[i])
    );
  end

  assign tr1  = pin_v[0];
  assign tr2  = pin_v[1];
  assign busy = (phase != PH_IDLE);

  p_one_active_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(act_v[0] && act_v[1]));

  p_active_in_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (act_v != '0) |-> busy);

  p_idle_level_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (tr1 == cfg_inv1 && tr2 == cfg_inv2));

  p_tr2_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !dual_s) |-> (tr2 == cfg_inv2));
endmodule

// File: tb/tb_xfer_pulse_seq.sv
module tb_xfer_pulse_seq;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line_start = 1'b0, pix_en = 1'b0, cfg_dual = 1'b0;
  logic [W-1:0] cfg_w1 = '0, cfg_w2 = '0, cfg_wg = '0;
  logic cfg_inv1 = 1'b0, cfg_inv2 = 1'b0, cfg_dis1 = 1'b0, cfg_dis2 = 1'b0;
  logic tr1, tr2, busy;

  int n_chk = 0, n_bad = 0;
  string cur_req = "R1";
  bit cmp_on = 1'b0;

  always #5 clk = ~clk;

  xfer_pulse_seq #(.W(W)) dut (.*);

  // Reference model built from the requirements
  bit m_busy; int m_seg, m_left, m_w1, m_w2, m_wg; bit m_dual, m_d1, m_d2;

  function automatic int eff(int w); return (w == 0) ? 1 : w; endfunction
  function automatic int seg_len(int s);
    return (s == 1) ? m_w1 : (s == 3) ? m_w2 : m_wg;
  endfunction
  function automatic int line_len(int w1, int w2, int wg, bit dual);
    return dual ? 3*eff(wg) + eff(w1) + eff(w2) : 2*eff(wg) + eff(w1);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy <= 1'b0; m_seg <= 0; m_left <= 0;
    end else if (!m_busy) begin
      if (line_start) begin
        m_busy <= 1'b1; m_seg <= 0; m_left <= eff(int'(cfg_wg));
        m_w1 <= eff(int'(cfg_w1)); m_w2 <= eff(int'(cfg_w2)); m_wg <= eff(int'(cfg_wg));
        m_dual <= cfg_dual; m_d1 <= cfg_dis1; m_d2 <= cfg_dis2;
      end
    end else if (pix_en) begin
      if (m_left > 1) m_left <= m_left - 1;
      else if (m_seg == (m_dual ? 4 : 2)) m_busy <= 1'b0;
      else begin m_seg <= m_seg + 1; m_left <= seg_len(m_seg + 1); end
    end
  end

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (cmp_on && rst_n) begin
      bit e1, e2;
      e1 = cfg_inv1 ^ (m_busy && m_seg == 1 && !m_d1);
      e2 = cfg_inv2 ^ (m_busy && m_seg == 3 && !m_d2);
      check(busy == m_busy, cur_req, "busy", int'(busy), int'(m_busy));
      check(tr1 == e1, cur_req, "tr1", int'(tr1), int'(e1));
      check(tr2 == e2, cur_req, "tr2", int'(tr2), int'(e2));
    end
  end

  task automatic run_line(int w1, int w2, int wg, bit dual, bit d1, bit d2,
                          bit i1, bit i2, int pen, bit poke, bit chg, string req);
    int busy_n = 0;
    @(negedge clk); #1;
    cur_req = req;
    cfg_w1 = W'(w1); cfg_w2 = W'(w2); cfg_wg = W'(wg);
    cfg_dual = dual; cfg_dis1 = d1; cfg_dis2 = d2; cfg_inv1 = i1; cfg_inv2 = i2;
    line_start = 1'b1;
    pix_en = ($urandom_range(99) < pen);
    for (int cyc = 0; cyc < 5000; cyc++) begin
      @(negedge clk);
      if (busy) busy_n++;
      else break;
      #1;
      pix_en = ($urandom_range(99) < pen);
      line_start = poke && ($urandom_range(2) == 0);
      if (chg && cyc == 1) begin  // R10: mid-line reprogramming
        cfg_w1 = W'($urandom_range(9)); cfg_w2 = W'($urandom_range(9));
        cfg_wg = W'($urandom_range(9)); cfg_dual = ~dual;
        cfg_dis1 = ~d1; cfg_dis2 = ~d2;
      end
    end
    #1; line_start = 1'b0;
    if (pen >= 100)
      check(busy_n == line_len(w1, w2, wg, dual), req, "line length",
            busy_n, line_len(w1, w2, wg, dual));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R1: reset levels, non-inverted and inverted
    check(busy == 1'b0, "R1", "busy in reset", int'(busy), 0);
    check(tr1 == 1'b0 && tr2 == 1'b0, "R1", "pulse idle level", int'({tr1, tr2}), 0);
    #1; rst_n = 1'b1;
    @(negedge clk); #1; cfg_inv1 = 1'b1; cfg_inv2 = 1'b1;
    @(negedge clk);
    check(tr1 == 1'b1 && tr2 == 1'b1, "R6", "inverted idle level", int'({tr1, tr2}), 3);
    #1; cfg_inv1 = 1'b0; cfg_inv2 = 1'b0;
    cmp_on = 1'b1;

    // R9: idle pixel enables do not start anything
    cur_req = "R2";
    repeat (6) begin @(negedge clk); #1; pix_en = ~pix_en; end

    run_line(3, 2, 2, 1'b0, 0, 0, 0, 0, 100, 0, 0, "R3");   // R5 single mode
    run_line(3, 4, 2, 1'b1, 0, 0, 0, 0, 100, 0, 0, "R3");   // dual order
    run_line(0, 0, 0, 1'b1, 0, 0, 0, 0, 100, 0, 0, "R4");   // zero widths
    run_line(2, 5, 1, 1'b0, 0, 0, 0, 0, 100, 0, 0, "R5");
    run_line(4, 3, 2, 1'b1, 0, 0, 1, 1, 100, 0, 0, "R6");   // inverted pulses
    run_line(4, 3, 2, 1'b1, 1, 0, 0, 0, 100, 0, 0, "R7");   // first disabled
    run_line(4, 3, 2, 1'b1, 1, 1, 0, 1, 100, 0, 0, "R7");   // both disabled
    run_line(3, 3, 3, 1'b1, 0, 0, 0, 0, 100, 1, 0, "R8");   // strobes while busy
    run_line(3, 2, 2, 1'b1, 0, 0, 0, 0, 35, 0, 0, "R9");    // sparse enables
    run_line(5, 2, 3, 1'b0, 0, 1, 0, 0, 100, 0, 1, "R10");
    run_line(2, 6, 1, 1'b1, 1, 0, 0, 0, 100, 0, 1, "R10");
    run_line(255, 1, 1, 1'b1, 0, 0, 0, 0, 100, 0, 0, "R3"); // full-scale width

    for (int n = 0; n < 40; n++) begin
      run_line($urandom_range(6), $urandom_range(6), $urandom_range(4),
               1'($urandom_range(1)), 1'($urandom_range(1)), 1'($urandom_range(1)),
               1'($urandom_range(1)), 1'($urandom_range(1)),
               $urandom_range(3) == 0 ? 100 : 30 + $urandom_range(70),
               1'($urandom_range(1)), 1'($urandom_range(1)), "R11");
      repeat ($urandom_range(3)) @(negedge clk);
    end

    repeat (4) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule